// File: doc/BRIEF.md
# Modem Control and Status Register Pair

This block keeps the two modem-handshake registers of a 16550-style serial port. A control register drives the four handshake outputs (data terminal ready, request to send and two general-purpose outputs) and the loopback selector. A status register samples the four handshake inputs (clear to send, data set ready, carrier detect, ring indicator) through synchronizers. It keeps a sticky change flag for each input and raises one summary flag to the interrupt logic while any change flag is set.

A bus decoder reaches both registers through a byte-wide read/write strobe interface with a single address bit. Reading the status register returns its contents and then clears the change flags. For ring indicator, only the end of a ring (1 to 0) counts as a change. With loopback selected, the handshake outputs are forced inactive. A status read then reports the control bits in place of the input pins, and the loopback select output tells the serial datapath to route transmitted bytes back into the receiver.

Top module: `mdm_regs`

## Requirements
- R1: After reset the status register reads 0xB0 (carrier, data-set-ready and clear-to-send high, ring low, no change flags), the control register reads 0x08, out2_o is 1, rts_o, dtr_o, out1_o, loop_o and delta_any_o are 0.
- R2: A write with reg_addr=0 stores reg_wdata[4:0] in the control register: bit0 data terminal ready, bit1 request to send, bit2 OUT1, bit3 OUT2, bit4 loopback. Bits 7:5 read back as 0. Outside loopback dtr_o, rts_o, out1_o and out2_o follow bits 0..3. Writes with reg_addr=1 change nothing.
- R3: Status bits 7,6,5,4 show carrier detect, ring, data set ready and clear to send. A pin change driven before a rising edge becomes visible after the third rising edge (two synchronizer stages plus the status register).
- R4: A change in either direction of carrier detect, data set ready or clear to send sets status bit 3, 1 or 0 respectively. The flag stays set until a status read.
- R5: Status bit 2 is set when ring indicator falls from 1 to 0, and never when it rises.
- R6: A status read (reg_rd with reg_addr=1) outside loopback returns the current value and clears bits 3:0 on that edge. A pin change that is registered on the same edge as the read keeps its flag set.
- R7: delta_any_o is 1 exactly while at least one stored change flag is set.
- R8: In loopback a status read returns OUT2 on bit 7, OUT1 on bit 6, data terminal ready on bit 5, request to send on bit 4 and 0 on bits 3:0. Such a read does not clear the stored change flags, which reappear when loopback ends.
- R9: In loopback loop_o is 1 and rts_o, dtr_o, out1_o and out2_o are held at 0, while the control register keeps its stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (status read side effect) |
| reg_addr | input | 1 | 0 control register, 1 status register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| cts_i | input | 1 | Clear-to-send pin, asynchronous |
| dsr_i | input | 1 | Data-set-ready pin, asynchronous |
| dcd_i | input | 1 | Carrier-detect pin, asynchronous |
| ri_i | input | 1 | Ring-indicator pin, asynchronous |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Data-terminal-ready output |
| out1_o | output | 1 | General-purpose output 1 |
| out2_o | output | 1 | General-purpose output 2 |
| loop_o | output | 1 | Loopback select for the serial datapath |
| delta_any_o | output | 1 | Any change flag set |

## Verification
The clearing read and the setting of a new change flag can land on the same edge. The bench provokes this by pre-setting the clear-to-send flag, then driving a data-set-ready change so that it leaves the synchronizer in exactly the cycle the read strobe is held. It judges three things: the read returns the old contents, the old flag is gone afterwards, and the new flag survives. A second overlap, a read issued in loopback while flags are pending, is judged by leaving loopback and finding the flags intact.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int DATA_W = 8;
  localparam int CTL_W  = 5;
  localparam int LN_W   = 4;

  // control bit positions
  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_OUT1 = 2;
  localparam int CB_OUT2 = 3;
  localparam int CB_LOOP = 4;

  // line positions inside the 4-bit line vector (status bit = 4 + index)
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;

  localparam logic [LN_W-1:0]  LINE_RST = 4'b1011;
  localparam logic [CTL_W-1:0] CTL_RST  = 5'b01000;

  typedef enum logic {
    A_CTRL = 1'b0,
    A_STAT = 1'b1
  } mdm_addr_e;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb chain_d[s] = d_i;
      end else begin : g_next
        always_comb chain_d[s] = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RST_VAL;
        else        chain_q[s] <= chain_d[s];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic [CTL_W-1:0] ctrl_o
);
  logic [CTL_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i) ctrl_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTL_RST;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  // R2: without a write the control register holds
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(ctrl_q));
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LN_W-1:0] line_i,
  input  logic            clr_i,
  output logic [LN_W-1:0] line_o,
  output logic [LN_W-1:0] delta_o
);
  logic [LN_W-1:0] line_q, line_d;
  logic [LN_W-1:0] delta_q, delta_d;
  logic [LN_W-1:0] flip, set_v;
  logic            line_en, delta_en;

  always_comb begin
    flip          = line_i ^ line_q;
    set_v         = flip;
    // ring counts only at the end of a ring
    set_v[LN_RI]  = line_q[LN_RI] & ~line_i[LN_RI];
    line_en       = |flip;
    line_d        = line_i;
    delta_en      = clr_i | (|set_v);
    delta_d       = (clr_i ? '0 : delta_q) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= LINE_RST;
    else if (line_en) line_q <= line_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        delta_q <= '0;
    else if (delta_en) delta_q <= delta_d;
  end

  assign line_o  = line_q;
  assign delta_o = delta_q;

  // R4: a carrier-detect change raises its flag on the next edge
  p_dcd_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_i[LN_DCD] != line_q[LN_DCD]) |=> delta_q[LN_DCD]);

  // R4: flags are sticky while no read clears them
  p_cts_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && delta_q[LN_CTS]) |=> delta_q[LN_CTS]);

  // R5: a rising ring never raises the ring flag
  p_ring_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_q[LN_RI] && line_i[LN_RI] && !delta_q[LN_RI]) |=> !delta_q[LN_RI]);

  // R6: a read with no concurrent change leaves no flags
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && (line_i == line_q)) |=> (delta_q == '0));
endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cts_i,
  input  logic              dsr_i,
  input  logic              dcd_i,
  input  logic              ri_i,
  output logic              rts_o,
  output logic              dtr_o,
  output logic              out1_o,
  output logic              out2_o,
  output logic              loop_o,
  output logic              delta_any_o
);
  localparam int PAD_W = DATA_W - CTL_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [RST_STAGES-1:0] rst_chain_q;
  logic                  srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain_q <= '0;
    else        rst_chain_q <= {rst_chain_q[RST_STAGES-2:0], 1'b1};
  end
  assign srst_n = rst_chain_q[RST_STAGES-1];

  logic [LN_W-1:0]  pins_raw, pins_sync;
  logic [LN_W-1:0]  line_q, delta_q;
  logic [CTL_W-1:0] ctrl_q;
  logic             wr_ctrl, rd_stat, clr_flags, in_loop;
  logic [LN_W-1:0]  loop_lines;

  always_comb begin
    pins_raw          = '0;
    pins_raw[LN_CTS]  = cts_i;
    pins_raw[LN_DSR]  = dsr_i;
    pins_raw[LN_RI]   = ri_i;
    pins_raw[LN_DCD]  = dcd_i;
  end

  mdm_sync #(.W(LN_W), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d_i   (pins_raw),
    .q_o   (pins_sync)
  );

  always_comb begin
    wr_ctrl   = reg_wr && (mdm_addr_e'(reg_addr) == A_CTRL);
    rd_stat   = reg_rd && (mdm_addr_e'(reg_addr) == A_STAT);
    in_loop   = ctrl_q[CB_LOOP];
    clr_flags = rd_stat && !in_loop;
  end

  mdm_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en_i (wr_ctrl),
    .wdata_i (reg_wdata[CTL_W-1:0]),
    .ctrl_o  (ctrl_q)
  );

  mdm_status u_stat (
    .clk     (clk),
    .rst_n   (srst_n),
    .line_i  (pins_sync),
    .clr_i   (clr_flags),
    .line_o  (line_q),
    .delta_o (delta_q)
  );

  // loopback crossover: control bits appear on the status lines
  always_comb begin
    loop_lines         = '0;
    loop_lines[LN_DCD] = ctrl_q[CB_OUT2];
    loop_lines[LN_RI]  = ctrl_q[CB_OUT1];
    loop_lines[LN_DSR] = ctrl_q[CB_DTR];
    loop_lines[LN_CTS] = ctrl_q[CB_RTS];
  end

  always_comb begin
    if (mdm_addr_e'(reg_addr) == A_CTRL) reg_rdata = {{PAD_W{1'b0}}, ctrl_q};
    else if (in_loop)                    reg_rdata = {loop_lines, {LN_W{1'b0}}};
    else                                 reg_rdata = {line_q, delta_q};
  end

  always_comb begin
    dtr_o       = ctrl_q[CB_DTR]  & ~in_loop;
    rts_o       = ctrl_q[CB_RTS]  & ~in_loop;
    out1_o      = ctrl_q[CB_OUT1] & ~in_loop;
    out2_o      = ctrl_q[CB_OUT2] & ~in_loop;
    loop_o      = in_loop;
    delta_any_o = |delta_q;
  end

  // R9: writing loopback on forces every handshake output low next cycle
  p_loop_gate_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_ctrl && reg_wdata[CB_LOOP]) |=>
      (loop_o && !rts_o && !dtr_o && !out1_o && !out2_o));

  // R8: a status read in loopback does not drop pending flags
  p_loop_keep_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_stat && in_loop && (delta_q != '0)) |=> delta_any_o);

  // R7: summary flag low means the status low nibble reads zero
  p_any_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (!delta_any_o && !in_loop && (mdm_addr_e'(reg_addr) == A_STAT))
      |-> (reg_rdata[LN_W-1:0] == '0));
endmodule

// File: tb/tb_mdm_regs.sv
module tb_mdm_regs;
  logic       clk, rst_n;
  logic       reg_wr, reg_rd, reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       cts_i, dsr_i, dcd_i, ri_i;
  logic       rts_o, dtr_o, out1_o, out2_o, loop_o, delta_any_o;
  int         n_chk, n_fail;
  logic [7:0] v;

  mdm_regs dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cts_i(cts_i), .dsr_i(dsr_i), .dcd_i(dcd_i), .ri_i(ri_i),
    .rts_o(rts_o), .dtr_o(dtr_o), .out1_o(out1_o), .out2_o(out2_o),
    .loop_o(loop_o), .delta_any_o(delta_any_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
  endtask

  task automatic t_reset();
    rd_reg(1'b1, v); chk("R1 status", v, 8'hB0);
    rd_reg(1'b0, v); chk("R1 control", v, 8'h08);
    chk("R1 outputs", {2'b0, delta_any_o, loop_o, out2_o, out1_o, rts_o, dtr_o}, 8'h08);
  endtask

  task automatic t_ctrl();
    wr_reg(1'b0, 8'hE3);
    rd_reg(1'b0, v); chk("R2 readback", v, 8'h03);
    chk("R2 pins a", {4'b0, out2_o, out1_o, rts_o, dtr_o}, 8'h03);
    wr_reg(1'b0, 8'h0C);
    chk("R2 pins b", {4'b0, out2_o, out1_o, rts_o, dtr_o}, 8'h0C);
    wr_reg(1'b1, 8'hFF);
    rd_reg(1'b0, v); chk("R2 status write ignored ctrl", v, 8'h0C);
    rd_reg(1'b1, v); chk("R2 status write ignored stat", v, 8'hB0);
    wr_reg(1'b0, 8'h08);
  endtask

  task automatic t_follow();
    @(negedge clk); dcd_i = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R3 not yet after two edges", {7'b0, delta_any_o}, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R3 visible after third edge", {7'b0, delta_any_o}, 8'h01);
    rd_reg(1'b1, v); chk("R4 dcd flag", v, 8'h38);
    chk("R7 any low after read", {7'b0, delta_any_o}, 8'h00);
    rd_reg(1'b1, v); chk("R6 cleared", v, 8'h30);
    @(negedge clk); dcd_i = 1'b1; cts_i = 1'b0;
    settle();
    chk("R7 any high", {7'b0, delta_any_o}, 8'h01);
    rd_reg(1'b1, v); chk("R4 dcd and cts flags", v, 8'hA9);
    @(negedge clk); cts_i = 1'b1;
    settle();
    rd_reg(1'b1, v); chk("R4 cts back", v, 8'hB1);
    rd_reg(1'b1, v); chk("R6 clean", v, 8'hB0);
  endtask

  task automatic t_ring();
    @(negedge clk); ri_i = 1'b1;
    settle();
    chk("R5 no flag on rise (any)", {7'b0, delta_any_o}, 8'h00);
    rd_reg(1'b1, v); chk("R5 rise", v, 8'hF0);
    @(negedge clk); ri_i = 1'b0;
    settle();
    rd_reg(1'b1, v); chk("R5 fall sets bit 2", v, 8'hB4);
    rd_reg(1'b1, v); chk("R6 ring flag cleared", v, 8'hB0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk); cts_i = 1'b0;
    settle();
    @(negedge clk); dsr_i = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 1'b1;
    #1 v = reg_rdata;
    chk("R6 read returns old value", v, 8'hA1);
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    chk("R6 concurrent flag survives (any)", {7'b0, delta_any_o}, 8'h01);
    rd_reg(1'b1, v); chk("R6 only new flag", v, 8'h82);
    @(negedge clk); cts_i = 1'b1; dsr_i = 1'b1;
    settle();
    rd_reg(1'b1, v); chk("R4 restore", v, 8'hB3);
  endtask

  task automatic t_loop();
    @(negedge clk); dcd_i = 1'b0;
    settle();
    wr_reg(1'b0, 8'h15);
    chk("R9 outputs gated", {3'b0, loop_o, out2_o, out1_o, rts_o, dtr_o}, 8'h10);
    rd_reg(1'b0, v); chk("R9 control kept", v, 8'h15);
    rd_reg(1'b1, v); chk("R8 crossover a", v, 8'h60);
    chk("R8 flags kept (any)", {7'b0, delta_any_o}, 8'h01);
    wr_reg(1'b0, 8'h1A);
    chk("R9 outputs gated b", {3'b0, loop_o, out2_o, out1_o, rts_o, dtr_o}, 8'h10);
    rd_reg(1'b1, v); chk("R8 crossover b", v, 8'h90);
    wr_reg(1'b0, 8'h08);
    chk("R2 outputs after loop", {3'b0, loop_o, out2_o, out1_o, rts_o, dtr_o}, 8'h08);
    rd_reg(1'b1, v); chk("R8 flag reappears", v, 8'h38);
    @(negedge clk); dcd_i = 1'b1;
    settle();
    rd_reg(1'b1, v); chk("R4 dcd restored", v, 8'hB8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    cts_i = 1'b1; dsr_i = 1'b1; dcd_i = 1'b1; ri_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    settle();
    t_reset();
    t_ctrl();
    t_follow();
    t_ring();
    t_same_cycle();
    t_loop();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule